// File: doc/BRIEF.md
# Table-Vectored Interrupt Entry Sequencer

This block performs interrupt entry for a small 8-bit processor with a 16-bit address space. Interrupts run in table-vectored mode. When a request is taken, the block runs an acknowledge phase and reads one byte from the interrupting device over the shared data bus. It then saves the running program counter on a downward-growing stack. Next it combines a processor-held page byte with the device byte to form the address of a table slot. Finally it reads the handler address from that slot, two bytes with the low byte first, and hands the address back as the new program counter.

The sequence always lasts 19 clocks: 7 clocks of acknowledge, two 3-clock stack writes, and two 3-clock table reads. A request is taken only when the interrupt-enable flag is set and no entry is already running. Taking a request clears the flag, so the same request cannot start a second entry. The page register is written through a simple load port. It is sampled at the moment the device byte is captured.

Top module: `irq_vec_seq`

## Requirements
- R1: After reset the page register, enable flag, busy, acknowledge, write strobe, done, new-PC and new-SP outputs are all 0.
- R2: A request starts an entry only when the enable flag is 1 and the block is idle. Starting an entry clears the flag. If an enable-set pulse arrives in the same cycle as the start, the start wins and the flag ends cleared. A request while the flag is 0 is ignored.
- R3: `irq_ack` is high for exactly the 7 cycles after the start edge. The device byte is taken from `bus_rdata` in the last of those cycles.
- R4: `bus_we` is high in exactly two cycles, the 10th and 13th after the start. The first write stores PC[15:8] at SP-1 and the second stores PC[7:0] at SP-2, with modulo 2^16 wrap.
- R5: The table pointer is {page, device byte with bit 0 forced to 0}. The low handler byte is read at the pointer and the high byte at pointer+1. `bus_re` is high during the 6 read cycles.
- R6: `done` is high for one cycle, the 20th cycle after the start edge (19 clocks of sequence). In that cycle `pc_out` holds {byte at pointer+1, byte at pointer} and `sp_out` holds SP-2.
- R7: `pc_out` and `sp_out` change only at the end of an entry and stay stable otherwise.
- R8: `page_ld` high loads `page_din` into the page register, visible on `page_q` one cycle later.
- R9: A request held high during an entry neither restarts nor stretches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request level |
| ie_set | input | 1 | Pulse that sets the interrupt-enable flag |
| page_ld | input | 1 | Load strobe for the page register |
| page_din | input | 8 | Page register load value |
| pc_in | input | 16 | Current program counter, captured at start |
| sp_in | input | 16 | Current stack pointer, captured at start |
| bus_rdata | input | 8 | Data bus read value (device byte or memory byte) |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_we | output | 1 | Memory write strobe |
| bus_re | output | 1 | Memory read enable |
| irq_ack | output | 1 | Interrupt acknowledge strobe |
| busy | output | 1 | Entry sequence in progress |
| ie_flag | output | 1 | Interrupt-enable flag |
| page_q | output | 8 | Page register contents |
| done | output | 1 | One-cycle pulse: new PC and SP valid |
| pc_out | output | 16 | Handler address |
| sp_out | output | 16 | Stack pointer after the push |

## Verification
Two events can land on the same edge: taking a request and a pulse that sets the enable flag. The bench provokes this by raising the request together with an enable-set pulse while the flag is already set. It judges the result by checking that `ie_flag` reads 0 in the first sequence cycle. It also holds the request high through the whole entry and beyond, and checks that no second acknowledge appears after `done`. The sweeps cover even and odd device bytes, pages 0x00 and 0xFF, and stack pointers that wrap below zero.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACK   = 2'd1,
    PH_PUSH  = 2'd2,
    PH_FETCH = 2'd3
  } ivs_phase_e;
endpackage

// File: rtl/ivs_ctrl.sv
module ivs_ctrl
  import ivs_pkg::*;
#(
  parameter int ACK_CYC  = 7,
  parameter int SLOT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output ivs_phase_e phase,
  output logic       slot,
  output logic       vec_take,
  output logic       wr_stb,
  output logic       rd_take,
  output logic       fin
);
  localparam int CMAX = (ACK_CYC > SLOT_CYC) ? ACK_CYC : SLOT_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  ivs_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          slot_q;
  logic          ack_end, slot_end;

  assign ack_end  = (cnt_q == CW'(ACK_CYC - 1));
  assign slot_end = (cnt_q == CW'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      slot_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_ACK;
            cnt_q   <= '0;
          end
        end
        PH_ACK: begin
          if (ack_end) begin
            phase_q <= PH_PUSH;
            cnt_q   <= '0;
            slot_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PUSH, PH_FETCH: begin
          if (slot_end) begin
            cnt_q  <= '0;
            slot_q <= ~slot_q;
            if (slot_q) phase_q <= (phase_q == PH_PUSH) ? PH_FETCH : PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = phase_q;
  assign slot     = slot_q;
  assign vec_take = (phase_q == PH_ACK) && ack_end;
  assign wr_stb   = (phase_q == PH_PUSH) && slot_end;
  assign rd_take  = (phase_q == PH_FETCH) && slot_end;
  assign fin      = rd_take && slot_q;
endmodule

// File: rtl/ivs_regs.sv
module ivs_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ie_set,
  input  logic          page_ld,
  input  logic [DW-1:0] page_din,
  output logic [DW-1:0] page_q,
  output logic          ie_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (page_ld) page_q <= page_din;
      if (start)       ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ivs_datapath.sv
module ivs_datapath
  import ivs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  ivs_phase_e    phase,
  input  logic          slot,
  input  logic          vec_take,
  input  logic          rd_take,
  input  logic          fin,
  input  logic [DW-1:0] page,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] sp_out
);
  localparam logic [DW-1:0] EVEN_MASK = {{(DW-1){1'b1}}, 1'b0};

  logic [AW-1:0] pc_sv, sp_sv, ptr_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_sv  <= '0;
      sp_sv  <= '0;
      ptr_q  <= '0;
      lo_q   <= '0;
      done   <= 1'b0;
      pc_out <= '0;
      sp_out <= '0;
    end else begin
      done <= fin;
      if (start) begin
        pc_sv <= pc_in;
        sp_sv <= sp_in;
      end
      if (vec_take) ptr_q <= {page, rdata & EVEN_MASK};
      if (rd_take && !slot) lo_q <= rdata;
      if (fin) begin
        pc_out <= {rdata, lo_q};
        sp_out <= sp_sv - AW'(2);
      end
    end
  end

  always_comb begin
    addr = '0;
    unique case (phase)
      PH_PUSH:  addr = sp_sv - (slot ? AW'(2) : AW'(1));
      PH_FETCH: addr = ptr_q | AW'(slot);
      default:  addr = '0;
    endcase
  end

  assign wdata = slot ? pc_sv[DW-1:0] : pc_sv[AW-1:DW];
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
  import ivs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 2 * DW,
  parameter int ACK_CYC  = 7,
  parameter int SLOT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_req,
  input  logic          ie_set,
  input  logic          page_ld,
  input  logic [DW-1:0] page_din,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  output logic          irq_ack,
  output logic          busy,
  output logic          ie_flag,
  output logic [DW-1:0] page_q,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] sp_out
);
  ivs_phase_e phase;
  logic       slot, vec_take, wr_stb, rd_take, fin, start;

  assign start = irq_req && ie_flag && (phase == PH_IDLE);

  ivs_ctrl #(.ACK_CYC(ACK_CYC), .SLOT_CYC(SLOT_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .slot(slot),
    .vec_take(vec_take), .wr_stb(wr_stb), .rd_take(rd_take), .fin(fin)
  );

  ivs_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .start(start), .ie_set(ie_set),
    .page_ld(page_ld), .page_din(page_din), .page_q(page_q), .ie_q(ie_flag)
  );

  ivs_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .slot(slot),
    .vec_take(vec_take), .rd_take(rd_take), .fin(fin), .page(page_q),
    .pc_in(pc_in), .sp_in(sp_in), .rdata(bus_rdata), .addr(bus_addr),
    .wdata(bus_wdata), .done(done), .pc_out(pc_out), .sp_out(sp_out)
  );

  assign bus_we  = wr_stb;
  assign bus_re  = (phase == PH_FETCH);
  assign irq_ack = (phase == PH_ACK);
  assign busy    = (phase != PH_IDLE);
endmodule

// File: rtl/ivs_chk.sv
module ivs_chk #(
  parameter int AW      = 16,
  parameter int ACK_CYC = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_ack,
  input logic          bus_we,
  input logic          bus_re,
  input logic          busy,
  input logic          ie_flag,
  input logic          done,
  input logic [AW-1:0] pc_out,
  input logic [AW-1:0] sp_out
);
  logic [7:0] ack_run;
  always_ff @(posedge clk) begin
    if (rst)          ack_run <= '0;
    else if (irq_ack) ack_run <= (ack_run == 8'hFF) ? ack_run : ack_run + 1'b1;
    else              ack_run <= '0;
  end

  a_r3_ack_len: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_ack) |-> (ack_run == 8'(ACK_CYC)));
  a_r2_start_clears_ie: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ie_flag);
  a_r4_no_write_in_ack: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (irq_ack || bus_re)));
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pc_out) && $stable(sp_out)));
endmodule

bind irq_vec_seq ivs_chk #(.AW(AW), .ACK_CYC(ACK_CYC)) u_ivs_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .bus_we(bus_we), .bus_re(bus_re),
  .busy(busy), .ie_flag(ie_flag), .done(done), .pc_out(pc_out), .sp_out(sp_out)
);

// File: tb/tb_irq_vec_seq.sv
module tb_irq_vec_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0, ie_set = 1'b0, page_ld = 1'b0;
  logic [7:0]  page_din = '0, vec_drv = '0, memq;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr, pc_out, sp_out;
  logic [7:0]  bus_wdata, page_q;
  logic        bus_we, bus_re, irq_ack, busy, ie_flag, done;
  int          nchk = 0, nfail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vec_seq dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ie_set(ie_set), .page_ld(page_ld),
    .page_din(page_din), .pc_in(pc_in), .sp_in(sp_in), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .irq_ack(irq_ack), .busy(busy), .ie_flag(ie_flag), .page_q(page_q),
    .done(done), .pc_out(pc_out), .sp_out(sp_out)
  );

  function automatic logic [7:0] tbl(input logic [15:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) memq <= tbl(bus_addr);
  assign bus_rdata = irq_ack ? vec_drv : memq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_irq(input logic [7:0] pg, input logic [7:0] vec,
                         input logic [15:0] pc, input logic [15:0] sp,
                         input bit collide, input bit hold);
    logic [15:0] ptr, exp_pc, old_pc, old_sp;
    ptr    = {pg, vec & 8'hFE};
    exp_pc = {tbl(ptr | 16'h1), tbl(ptr)};
    old_pc = pc_out;
    old_sp = sp_out;
    @(negedge clk);
    page_ld = 1'b1; page_din = pg; ie_set = 1'b1;
    pc_in = pc; sp_in = sp; vec_drv = vec;
    @(negedge clk);
    page_ld = 1'b0; ie_set = 1'b0;
    chk(page_q == pg, "R8 page load", page_q, pg);
    chk(ie_flag == 1'b1, "R2 enable set", ie_flag, 1);
    irq_req = 1'b1; ie_set = collide;
    @(negedge clk);
    irq_req = hold; ie_set = 1'b0;
    for (int k = 0; k < 19; k++) begin
      chk(busy == 1'b1, "R9 busy held", busy, 1);
      chk(irq_ack == (k < 7), "R3 ack window", irq_ack, k < 7);
      chk(done == 1'b0, "R6 no early done", done, 0);
      if (k == 0) chk(ie_flag == 1'b0, "R2 start clears enable", ie_flag, 0);
      if (k == 9) begin
        chk(bus_we && bus_addr == sp - 16'd1 && bus_wdata == pc[15:8],
            "R4 high byte push", {bus_we, bus_addr, bus_wdata}, {1'b1, sp - 16'd1, pc[15:8]});
      end else if (k == 12) begin
        chk(bus_we && bus_addr == sp - 16'd2 && bus_wdata == pc[7:0],
            "R4 low byte push", {bus_we, bus_addr, bus_wdata}, {1'b1, sp - 16'd2, pc[7:0]});
      end else begin
        chk(bus_we == 1'b0, "R4 no stray write", bus_we, 0);
      end
      if (k == 13) chk(bus_re && bus_addr == ptr, "R5 low table addr", bus_addr, ptr);
      if (k == 16) chk(bus_re && bus_addr == (ptr | 16'h1), "R5 high table addr", bus_addr, ptr | 16'h1);
      if (k == 10) chk(pc_out == old_pc && sp_out == old_sp, "R7 pc held during entry", pc_out, old_pc);
      @(negedge clk);
    end
    chk(done == 1'b1, "R6 done at 19 clocks", done, 1);
    chk(pc_out == exp_pc, "R6 handler pc", pc_out, exp_pc);
    chk(sp_out == sp - 16'd2, "R6 final sp", sp_out, sp - 16'd2);
    chk(busy == 1'b0, "R9 no stretch", busy, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
      chk(irq_ack == 1'b0 && busy == 1'b0, "R2 no re-entry", {irq_ack, busy}, 0);
      chk(pc_out == exp_pc, "R7 pc stable after", pc_out, exp_pc);
    end
    irq_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nchk - nfail + 1 - 1, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(page_q == 0 && ie_flag == 0 && busy == 0 && irq_ack == 0, "R1 reset state",
        {page_q, ie_flag, busy, irq_ack}, 0);
    chk(bus_we == 0 && done == 0 && pc_out == 0 && sp_out == 0, "R1 reset outputs",
        {bus_we, done}, 0);
    irq_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 0 && irq_ack == 0, "R2 request ignored while disabled", {busy, irq_ack}, 0);
    end
    irq_req = 1'b0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  pg, vec;
      logic [15:0] pc, sp;
      pg  = (i == 1) ? 8'hFF : (i == 2) ? 8'h00 : 8'(i * 29 + 7);
      vec = 8'(i * 17 + 3);
      pc  = 16'(i * 4099 + 16'h1234);
      sp  = (i == 3) ? 16'h0001 : (i == 4) ? 16'h0000 : 16'(16'hF000 - i * 257);
      run_irq(pg, vec, pc, sp, (i % 4) == 1, (i % 3) == 0);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule